// File: doc/BRIEF.md
# Transmit PCOM Mailbox

This block is a 32-bit out-of-band mailbox for a packet PHY transmitter. Management software fills it through a 16-bit register port, one half-word at each of two addresses. When the transmit framer opens the PCOM field of a packet, a value that software has committed is moved into a shift register. It is then presented one bit at a time on a serial output while the framer steps through the field. The mailbox empties itself when the value is taken. At the end of a packet that carried a non-zero value, a level-type ready flag goes high for an event or interrupt register.

The commit rule depends on the order of access. Touching the low half, by read or write, holds back every outgoing field, which then carries zeros, until the high half is touched. Touching the high half arms the mailbox, and the next field start takes the value. Any access to either half drops the ready flag.

Top module: `pcom_mailbox`

## Requirements
- R1: After reset both halves read as zero, `tx_ready` is 0 and `pcom_bit` is 0.
- R2: The high half (bits 31:16) sits at address 2 and the low half (bits 15:0) at address 3. Writes take effect at the clock edge, and `reg_rdata` shows the addressed half in the same cycle as `reg_rd`.
- R3: After a read or write of the high half, the next `fld_start` sends the 32-bit value most significant bit first. During the k-th cycle with `bit_en` high after `fld_start` (k = 0..31), `pcom_bit` equals bit 31-k.
- R4: After an access to the low half, every packet carries an all-zero field until the high half is accessed. The stored value is kept for the later commit.
- R5: A field that starts with no armed value carries 32 zero bits.
- R6: A committed value is cleared when the field starts. From then on both halves read zero, and the value is sent in one packet only.
- R7: A write during a field in progress does not change the bits of that field. A high-half write made at that time arms the value for the following packet.
- R8: `tx_ready` rises in the cycle after `pkt_done` for a packet that carried a non-zero value. A packet with a zero field leaves `tx_ready` low.
- R9: Any read or write of either half clears `tx_ready` at the next edge. A clear wins over a set in the same cycle.
- R10: `pcom_bit` is 0 outside a field and after the 32nd bit of a field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed half |
| fld_start | input | 1 | Framer pulse: PCOM field begins |
| bit_en | input | 1 | Framer takes one field bit this cycle |
| pkt_done | input | 1 | Framer pulse: packet finished |
| pcom_bit | output | 1 | Serial PCOM field bit |
| tx_ready | output | 1 | Level flag: non-zero PCOM was sent |

## Verification
The hardest conditions to reach from the ports are collisions in time. The first is a register access in the very cycle of `pkt_done`, where clear and set of the ready flag meet. The second is a high-half write in the middle of a field, which must spare the bits in flight and still arm the next packet. The bench's packet task drives these strobes on the exact cycle: a read alongside `pkt_done`, and a write beside the eleventh `bit_en`. It then checks both the bits of the current packet and those of the packet after it. A low access followed by several packets, before any high access, shows that blanking persists and that the stored value survives it.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int WORD_W  = 16;
    localparam int FIELD_W = 2 * WORD_W;
    localparam int CNT_W   = $clog2(FIELD_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BLANK = 2'd1,
        ST_ARMED = 2'd2
    } arm_e;

    typedef struct packed {
        logic [FIELD_W-1:0] data;
        arm_e               st;
    } regs_s;

    typedef struct packed {
        logic [FIELD_W-1:0] shreg;
        logic [CNT_W-1:0]   cnt;
        logic               active;
        logic               nz;
    } shf_s;
endpackage

// File: rtl/mbox_regfile.sv
module mbox_regfile
    import mbox_pkg::*;
#(
    parameter int                ADDR_W  = 4,
    parameter logic [ADDR_W-1:0] HI_ADDR = 'h2,
    parameter logic [ADDR_W-1:0] LO_ADDR = 'h3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               rd,
    input  logic               wr,
    input  logic [WORD_W-1:0]  wdata,
    input  logic               fld_start,
    output logic [WORD_W-1:0]  rdata,
    output logic [FIELD_W-1:0] data,
    output logic               armed,
    output logic               any_acc
);
    regs_s r_d, r_q;
    logic  hi_sel, lo_sel, hi_acc, lo_acc, commit;

    always_comb begin
        hi_sel  = (addr == HI_ADDR);
        lo_sel  = (addr == LO_ADDR);
        hi_acc  = (rd || wr) && hi_sel;
        lo_acc  = (rd || wr) && lo_sel;
        any_acc = hi_acc || lo_acc;
        commit  = fld_start && (r_q.st == ST_ARMED);

        r_d = r_q;
        // taking the value empties the mailbox
        if (commit) begin
            r_d.data = '0;
            r_d.st   = ST_IDLE;
        end
        // a same-cycle write still lands, for the following packet
        if (wr && hi_sel) r_d.data[FIELD_W-1:WORD_W] = wdata;
        if (wr && lo_sel) r_d.data[WORD_W-1:0]       = wdata;
        if (lo_acc) r_d.st = ST_BLANK;
        if (hi_acc) r_d.st = ST_ARMED;

        if (hi_sel)      rdata = r_q.data[FIELD_W-1:WORD_W];
        else if (lo_sel) rdata = r_q.data[WORD_W-1:0];
        else             rdata = '0;

        data  = r_q.data;
        armed = (r_q.st == ST_ARMED);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.data <= '0;
            r_q.st   <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assert_commit_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !wr) |=> (data == '0));

    assert_lo_blanks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lo_acc |=> !armed);

    assert_hi_arms_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_acc |=> armed);
endmodule

// File: rtl/pcom_shifter.sv
module pcom_shifter
    import mbox_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fld_start,
    input  logic               bit_en,
    input  logic               pkt_done,
    input  logic               armed,
    input  logic [FIELD_W-1:0] data,
    output logic               pcom_bit,
    output logic               done_nz
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FIELD_W);

    shf_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (fld_start) begin
            s_d.shreg  = armed ? data : '0;
            s_d.cnt    = '0;
            s_d.active = 1'b1;
            s_d.nz     = armed && (data != '0);
        end else begin
            if (s_q.active && bit_en && (s_q.cnt < LAST)) begin
                s_d.shreg = {s_q.shreg[FIELD_W-2:0], 1'b0};
                s_d.cnt   = s_q.cnt + 1'b1;
            end
            if (pkt_done) begin
                s_d.active = 1'b0;
                s_d.nz     = 1'b0;
            end
        end
        done_nz  = pkt_done && s_q.active && s_q.nz;
        pcom_bit = s_q.active && (s_q.cnt < LAST) && s_q.shreg[FIELD_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.shreg  <= '0;
            s_q.cnt    <= '0;
            s_q.active <= 1'b0;
            s_q.nz     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= LAST);

    assert_blank_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_start && !armed) |=> (s_q.shreg == '0));

    assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.active |-> !pcom_bit);
endmodule

// File: rtl/pcom_mailbox.sv
module pcom_mailbox
    import mbox_pkg::*;
#(
    parameter int                ADDR_W  = 4,
    parameter logic [ADDR_W-1:0] HI_ADDR = 'h2,
    parameter logic [ADDR_W-1:0] LO_ADDR = 'h3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              fld_start,
    input  logic              bit_en,
    input  logic              pkt_done,
    output logic              pcom_bit,
    output logic              tx_ready
);
    logic [FIELD_W-1:0] mb_data;
    logic               mb_armed, any_acc, done_nz;
    logic               ready_d, ready_q;

    mbox_regfile #(
        .ADDR_W (ADDR_W),
        .HI_ADDR(HI_ADDR),
        .LO_ADDR(LO_ADDR)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (reg_addr),
        .rd       (reg_rd),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .fld_start(fld_start),
        .rdata    (reg_rdata),
        .data     (mb_data),
        .armed    (mb_armed),
        .any_acc  (any_acc)
    );

    pcom_shifter shf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fld_start(fld_start),
        .bit_en   (bit_en),
        .pkt_done (pkt_done),
        .armed    (mb_armed),
        .data     (mb_data),
        .pcom_bit (pcom_bit),
        .done_nz  (done_nz)
    );

    always_comb begin
        ready_d = ready_q;
        if (done_nz) ready_d = 1'b1;
        if (any_acc) ready_d = 1'b0;   // access wins over set
        tx_ready = ready_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= ready_d;
    end

    assert_acc_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        any_acc |=> !tx_ready);

    assert_nz_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_nz && !any_acc) |=> tx_ready);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_nz && !any_acc) |=> $stable(tx_ready));
endmodule

// File: tb/pcom_mailbox_tb.sv
`timescale 1ns/1ps
module pcom_mailbox_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_rd = 1'b0, reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        fld_start = 1'b0, bit_en = 1'b0, pkt_done = 1'b0;
    logic        pcom_bit, tx_ready;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    localparam logic [3:0] A_HI = 4'h2;
    localparam logic [3:0] A_LO = 4'h3;

    // {mode(0: low then high, 1: high only), value, expected field, expected ready}
    localparam int NV = 6;
    localparam logic [65:0] VEC [NV] = '{
        {1'b0, 32'hA5A5_0F0F, 32'hA5A5_0F0F, 1'b1},
        {1'b0, 32'h0000_0001, 32'h0000_0001, 1'b1},
        {1'b1, 32'h8001_0000, 32'h8001_0000, 1'b1},
        {1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0},
        {1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1},
        {1'b1, 32'h0000_0000, 32'h0000_0000, 1'b0}
    };

    always #2 clk = ~clk;

    pcom_mailbox dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fld_start(fld_start), .bit_en(bit_en), .pkt_done(pkt_done),
        .pcom_bit(pcom_bit), .tx_ready(tx_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // one packet; optional write beside bit 10, optional low read beside pkt_done
    task automatic send_pkt(output logic [31:0] got, input bit mid_wr,
                            input logic [3:0] ma, input logic [15:0] md,
                            input bit rd_at_done);
        got = '0;
        @(negedge clk);
        fld_start = 1'b1;
        @(negedge clk);
        fld_start = 1'b0;
        for (int k = 0; k < 32; k++) begin
            bit_en = 1'b1;
            if (mid_wr && k == 10) begin
                reg_addr = ma; reg_wdata = md; reg_wr = 1'b1;
            end
            #1 got[31-k] = pcom_bit;
            @(negedge clk);
            reg_wr = 1'b0;
        end
        #1 chk("R10 bit after field end", {31'b0, pcom_bit}, 32'd0);
        bit_en = 1'b0;
        @(negedge clk);
        pkt_done = 1'b1;
        if (rd_at_done) begin
            reg_addr = A_LO; reg_rd = 1'b1;
        end
        @(negedge clk);
        pkt_done = 1'b0; reg_rd = 1'b0;
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        logic [31:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 tx_ready", {31'b0, tx_ready}, 32'd0);
        chk("R1 pcom_bit", {31'b0, pcom_bit}, 32'd0);
        reg_read(A_HI, rd); chk("R1 high half", {16'b0, rd}, 32'd0);
        reg_read(A_LO, rd); chk("R1 low half", {16'b0, rd}, 32'd0);

        // R5 idle packet (low read last, so blanked)
        send_pkt(got, 1'b0, A_HI, 16'h0, 1'b0);
        chk("R5 idle field", got, 32'd0);

        // R2 register access
        reg_write(A_HI, 16'hBEEF); reg_write(A_LO, 16'h1234);
        reg_read(A_HI, rd); chk("R2 high readback", {16'b0, rd}, 32'h0000_BEEF);
        reg_read(A_LO, rd); chk("R2 low readback", {16'b0, rd}, 32'h0000_1234);

        // R4 low accessed last: several packets blanked, value kept
        send_pkt(got, 1'b0, A_HI, 16'h0, 1'b0); chk("R4 blanked pkt1", got, 32'd0);
        send_pkt(got, 1'b0, A_HI, 16'h0, 1'b0); chk("R4 blanked pkt2", got, 32'd0);
        chk("R4 no ready", {31'b0, tx_ready}, 32'd0);
        reg_read(A_HI, rd); chk("R4 value kept", {16'b0, rd}, 32'h0000_BEEF);
        send_pkt(got, 1'b0, A_HI, 16'h0, 1'b0); chk("R3 commit after high read", got, 32'hBEEF_1234);
        chk("R8 ready set", {31'b0, tx_ready}, 32'd1);
        send_pkt(got, 1'b0, A_HI, 16'h0, 1'b0); chk("R6 sent once", got, 32'd0);
        reg_read(A_LO, rd); chk("R9 low read clears", {31'b0, tx_ready}, 32'd0);

        // table walk: R3, R6, R8, R9
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][65] == 1'b0) reg_write(A_LO, VEC[i][48:33]);
            reg_write(A_HI, VEC[i][64:49]);
            send_pkt(got, 1'b0, A_HI, 16'h0, 1'b0);
            chk("R3 table field", got, VEC[i][32:1]);
            chk("R8 table ready", {31'b0, tx_ready}, {31'b0, VEC[i][0]});
            reg_read(A_LO, rd); chk("R6 low cleared", {16'b0, rd}, 32'd0);
            chk("R9 read clears", {31'b0, tx_ready}, 32'd0);
            reg_read(A_HI, rd); chk("R6 high cleared", {16'b0, rd}, 32'd0);
        end

        // R7 write during a field in progress
        reg_write(A_LO, 16'h2222); reg_write(A_HI, 16'h1111);
        send_pkt(got, 1'b1, A_HI, 16'h3333, 1'b0);
        chk("R7 in-flight field intact", got, 32'h1111_2222);
        send_pkt(got, 1'b0, A_HI, 16'h0, 1'b0);
        chk("R7 mid write sent next", got, 32'h3333_0000);
        chk("R8 ready after second", {31'b0, tx_ready}, 32'd1);

        // R9 clear beats set in the same cycle
        reg_write(A_LO, 16'h0005); reg_write(A_HI, 16'h0000);
        send_pkt(got, 1'b0, A_HI, 16'h0, 1'b1);
        chk("R3 small value", got, 32'h0000_0005);
        chk("R9 clear wins", {31'b0, tx_ready}, 32'd0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule